// File: doc/BRIEF.md
# Stuck-Bus Timeout and Recovery Clocker

This supervisor sits beside a two-wire bus buffer and watches the card-side data and clock lines. Whenever either line is low, a watchdog counts clock cycles; it is cleared only by a cycle in which both lines are high together. If the count reaches its limit, the block asks the connection sequencer to break the data and clock connections. It then waits a guard interval and drives an open-drain clock pulldown through a slow burst of recovery pulses. The burst is meant to free a slave device that is holding the data line low.

The burst ends early once data is seen high while the clock is released. It never exceeds a parameterised number of pulses. Once both lines are high, the disconnect request is dropped and the sequencer takes over reconnection. If the lines stay low, the watchdog runs again and the recovery attempt repeats. While the lockout input is low, the block is held quiet. Counting starts at the first cycle after lockout ends, so a card powered up into a stuck bus gets its recovery burst one timeout later. All durations are cycle counts set by parameters.

Top module: `stuck_bus_recovery`

## Requirements
- R1: `disc_req` rises at the TIMEOUT_CYCLES-th consecutive rising edge at which `enable` is high and `sda_in` or `scl_in` is low. With one edge fewer, nothing happens.
- R2: The watchdog count clears only at an edge where `sda_in` and `scl_in` are both high. A low that hands over from one line to the other, with no common high cycle, keeps the count running.
- R3: While `enable` is low, `disc_req`, `scl_pull` and `burst_active` are low from the next edge on. The watchdog starts counting from the first edge with `enable` high.
- R4: After `disc_req` rises, `scl_pull` stays low for exactly GUARD_CYCLES cycles before the first pulse.
- R5: Each recovery pulse asserts `scl_pull` (1 = pull clock low) for PULSE_LOW_CYCLES cycles and then releases it for PULSE_HIGH_CYCLES cycles. `burst_active` is high through both halves.
- R6: A burst contains at most MAX_PULSES pulses.
- R7: If both lines are sampled high during the release half of a pulse, the burst ends when that release half completes. The number of pulses delivered is the number of that pulse.
- R8: After a burst, `disc_req` falls at the first edge where both lines are sampled high.
- R9: If the lines do not become both high within TIMEOUT_CYCLES cycles after a burst ends, a new guard interval and a new burst follow. The gap with `scl_pull` low between the last pulse and the next pulse is PULSE_HIGH_CYCLES + TIMEOUT_CYCLES + GUARD_CYCLES cycles.
- R10: `scl_pull` is asserted only while `disc_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High once supply lockout has ended |
| sda_in | input | 1 | Sampled level of the card-side data line |
| scl_in | input | 1 | Sampled level of the card-side clock line |
| disc_req | output | 1 | Request to break the data and clock connections |
| scl_pull | output | 1 | Open-drain enable: 1 pulls the card-side clock low |
| burst_active | output | 1 | High while recovery pulses are being generated |

## Verification
A corrupted watchdog count shows up at `disc_req`: it rises one or more cycles early or late against the length of the low stretch, or it never rises. Handover and single-cycle-high stimuli separate a count that clears wrongly from a correct one. A wrong pulse counter or abort flag changes the number of `scl_pull` pulses in a burst, and this is visible when the burst ends. A broken phase counter changes pulse widths or the guard gap within one pulse period. A wrong hold state shows as `disc_req` falling without both lines high, or as a missing retry gap of exactly the expected length.

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery #(
  parameter int TIMEOUT_CYCLES    = 3_000_000,
  parameter int GUARD_CYCLES      = 4_000,
  parameter int PULSE_LOW_CYCLES  = 5_882,
  parameter int PULSE_HIGH_CYCLES = 5_882,
  parameter int MAX_PULSES        = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sda_in,
  input  logic scl_in,
  output logic disc_req,
  output logic scl_pull,
  output logic burst_active
);
  localparam int M1   = (TIMEOUT_CYCLES > GUARD_CYCLES) ? TIMEOUT_CYCLES : GUARD_CYCLES;
  localparam int M2   = (PULSE_LOW_CYCLES > PULSE_HIGH_CYCLES) ? PULSE_LOW_CYCLES : PULSE_HIGH_CYCLES;
  localparam int MAXD = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXD + 1);
  localparam int PW   = $clog2(MAX_PULSES + 1);

  typedef enum logic [2:0] {S_WATCH, S_GUARD, S_LOW, S_HIGH, S_HOLD} state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   npulse;
  logic            freed;

  wire both_high = sda_in & scl_in;
  wire to_hit    = (cnt == CW'(TIMEOUT_CYCLES - 1));
  wire grd_hit   = (cnt == CW'(GUARD_CYCLES - 1));
  wire low_hit   = (cnt == CW'(PULSE_LOW_CYCLES - 1));
  wire high_hit  = (cnt == CW'(PULSE_HIGH_CYCLES - 1));
  wire last_p    = (npulse == PW'(MAX_PULSES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_WATCH;
      cnt    <= '0;
      npulse <= '0;
      freed  <= 1'b0;
    end else if (!enable) begin
      st     <= S_WATCH;
      cnt    <= '0;
      npulse <= '0;
      freed  <= 1'b0;
    end else begin
      unique case (st)
        S_WATCH: begin
          if (both_high)   cnt <= '0;
          else if (to_hit) begin st <= S_GUARD; cnt <= '0; end
          else             cnt <= cnt + 1'b1;
        end
        S_GUARD: begin
          if (grd_hit) begin
            st     <= S_LOW;
            cnt    <= '0;
            npulse <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_LOW: begin
          if (low_hit) begin
            st    <= S_HIGH;
            cnt   <= '0;
            freed <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        S_HIGH: begin
          if (both_high) freed <= 1'b1;
          if (high_hit) begin
            cnt <= '0;
            if (freed || both_high || last_p) st <= S_HOLD;
            else begin
              st     <= S_LOW;
              npulse <= npulse + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          if (both_high)   begin st <= S_WATCH; cnt <= '0; end
          else if (to_hit) begin st <= S_GUARD; cnt <= '0; end
          else             cnt <= cnt + 1'b1;
        end
        default: begin
          st  <= S_WATCH;
          cnt <= '0;
        end
      endcase
    end
  end

  assign disc_req     = (st != S_WATCH);
  assign scl_pull     = (st == S_LOW);
  assign burst_active = (st == S_LOW) || (st == S_HIGH);
endmodule

// File: rtl/stuck_bus_recovery_chk.sv
module stuck_bus_recovery_chk #(
  parameter int TIMEOUT_CYCLES    = 3_000_000,
  parameter int GUARD_CYCLES      = 4_000,
  parameter int PULSE_LOW_CYCLES  = 5_882,
  parameter int PULSE_HIGH_CYCLES = 5_882,
  parameter int MAX_PULSES        = 16
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sda_in,
  input logic scl_in,
  input logic disc_req,
  input logic scl_pull,
  input logic burst_active
);
  logic [31:0] low_run;
  logic [31:0] idle_run;
  logic [31:0] pcount;
  logic        pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      idle_run <= '0;
      pcount   <= '0;
      pull_q   <= 1'b0;
    end else begin
      pull_q   <= scl_pull;
      low_run  <= scl_pull ? low_run + 1 : '0;
      idle_run <= scl_pull ? '0 : ((idle_run < 32'hFFFF) ? idle_run + 1 : idle_run);
      if (!disc_req || idle_run > PULSE_HIGH_CYCLES) pcount <= '0;
      else if (scl_pull && !pull_q) pcount <= pcount + 1;
    end
  end

  assert_pull_needs_disc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> disc_req);

  assert_lockout_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!disc_req && !scl_pull && !burst_active));

  assert_disc_rise_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disc_req) |-> $past(enable && !(sda_in && scl_in)));

  assert_disc_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disc_req) |-> ($past(sda_in && scl_in) || !$past(enable)));

  assert_low_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull) && $past(enable)) |-> (low_run == PULSE_LOW_CYCLES));

  assert_pull_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> burst_active);

  assert_burst_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pcount <= MAX_PULSES);
endmodule

bind stuck_bus_recovery stuck_bus_recovery_chk #(
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .GUARD_CYCLES(GUARD_CYCLES),
  .PULSE_LOW_CYCLES(PULSE_LOW_CYCLES), .PULSE_HIGH_CYCLES(PULSE_HIGH_CYCLES),
  .MAX_PULSES(MAX_PULSES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sda_in(sda_in), .scl_in(scl_in),
  .disc_req(disc_req), .scl_pull(scl_pull), .burst_active(burst_active)
);

// File: tb/stuck_bus_recovery_tb_top.sv
module stuck_bus_recovery_tb_top;
  localparam int T = 40;
  localparam int G = 6;
  localparam int L = 4;
  localparam int H = 3;
  localparam int M = 16;

  localparam int K_TO = 0, K_GAP = 1, K_PUL = 2, K_DROP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic slv_sda_low = 1'b0;
  logic slv_scl_low = 1'b0;
  logic disc_req, scl_pull, burst_active;
  logic sda_in, scl_in;

  assign sda_in = !slv_sda_low;
  assign scl_in = !(slv_scl_low || scl_pull);

  always #5 clk = ~clk;

  stuck_bus_recovery #(
    .TIMEOUT_CYCLES(T), .GUARD_CYCLES(G), .PULSE_LOW_CYCLES(L),
    .PULSE_HIGH_CYCLES(H), .MAX_PULSES(M)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sda_in(sda_in), .scl_in(scl_in),
    .disc_req(disc_req), .scl_pull(scl_pull), .burst_active(burst_active)
  );

  typedef struct {int kind; int val; string req;} item_t;
  item_t exp_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic string kname(int k);
    case (k)
      K_TO:    return "timeout";
      K_GAP:   return "gap";
      K_PUL:   return "pulses";
      default: return "drop";
    endcase
  endfunction

  task automatic expect_item(int k, int v, string r);
    exp_q.push_back('{k, v, r});
  endtask

  task automatic got(int k, int v);
    item_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R1-R10 scope: unexpected %s=%0d, expected nothing", kname(k), v);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.val != v) begin
        fails++;
        $display("FAIL %s: got %s=%0d expected %s=%0d", e.req, kname(k), v, kname(e.kind), e.val);
      end
    end
  endtask

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor
  int low_run = 0, gap = 0, npulse = 0, prun = 0;
  logic p_disc = 0, p_pull = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (disc_req && !p_disc) got(K_TO, low_run);
      if (!disc_req && p_disc) begin
        if (npulse > 0) begin got(K_PUL, npulse); npulse = 0; end
        got(K_DROP, 0);
      end
      if (scl_pull && !p_pull) begin
        if (npulse == 0) got(K_GAP, gap);
        else check(gap == H, "R5 release width", gap, H);
        npulse++;
        prun = 1;
        gap = 0;
      end else if (scl_pull) prun++;
      if (!scl_pull && p_pull) check(prun == L, "R5 low width", prun, L);
      if (!scl_pull && disc_req) begin
        if (!p_disc) gap = 1; else gap++;
        if (gap == H + 1 && npulse > 0) begin got(K_PUL, npulse); npulse = 0; end
      end
      if (!enable || (sda_in && scl_in) || disc_req) low_run = 0;
      else low_run++;
      p_disc = disc_req;
      p_pull = scl_pull;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drain;
    wait (exp_q.size() == 0);
    step(5);
  endtask

  task automatic finish_up;
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R1-R10 scope: %0d expected items never seen, actual 0 expected %0d", exp_q.size(), exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish, queue=%0d", exp_q.size());
      finish_up();
    end
  end

  initial begin
    step(3);
    check(!disc_req && !scl_pull && !burst_active, "R3 reset quiet", {disc_req, scl_pull, burst_active}, 0);
    rst_n = 1'b1;
    step(3);

    // R1 boundary: one edge short of the timeout
    slv_sda_low = 1;
    step(T - 1);
    slv_sda_low = 0;
    step(5);
    check(!disc_req, "R1 no timeout at T-1", disc_req, 0);

    // R1 R4 R7 R8: data stuck, freed after third pulse
    expect_item(K_TO, T, "R1");
    expect_item(K_GAP, G, "R4");
    expect_item(K_PUL, 3, "R7");
    expect_item(K_DROP, 0, "R8");
    slv_sda_low = 1;
    repeat (3) @(negedge scl_pull);
    #2 slv_sda_low = 0;
    drain();

    // R2: handover from data low to clock low without a common high
    expect_item(K_TO, T, "R2 handover");
    expect_item(K_GAP, G, "R4");
    expect_item(K_PUL, M, "R6");
    expect_item(K_DROP, 0, "R8");
    slv_sda_low = 1;
    step(10);
    slv_sda_low = 0;
    slv_scl_low = 1;
    @(negedge burst_active);
    @(posedge clk);
    #2 slv_scl_low = 0;
    drain();

    // R2: single common-high cycle restarts the count
    expect_item(K_TO, T, "R2 blip");
    expect_item(K_GAP, G, "R4");
    expect_item(K_PUL, 1, "R7");
    expect_item(K_DROP, 0, "R8");
    slv_sda_low = 1;
    step(15);
    slv_sda_low = 0;
    step(1);
    slv_sda_low = 1;
    @(negedge scl_pull);
    #2 slv_sda_low = 0;
    drain();

    // R9: full burst, retry, then release during second burst
    expect_item(K_TO, T, "R1");
    expect_item(K_GAP, G, "R4");
    expect_item(K_PUL, M, "R6");
    expect_item(K_GAP, H + T + G, "R9");
    expect_item(K_PUL, 2, "R9");
    expect_item(K_DROP, 0, "R8");
    slv_sda_low = 1;
    repeat (M + 2) @(negedge scl_pull);
    #2 slv_sda_low = 0;
    drain();

    // R3: lockout holds the block quiet, counting starts when it ends
    enable = 0;
    step(2);
    slv_sda_low = 1;
    step(3 * T);
    check(!disc_req && !scl_pull && !burst_active, "R3 lockout quiet", {disc_req, scl_pull, burst_active}, 0);
    expect_item(K_TO, T, "R3");
    expect_item(K_GAP, G, "R4");
    expect_item(K_PUL, 1, "R7");
    expect_item(K_DROP, 0, "R8");
    enable = 1;
    @(negedge scl_pull);
    #2 slv_sda_low = 0;
    drain();

    check(!scl_pull && !disc_req, "R10 idle after recovery", {disc_req, scl_pull}, 0);
    done = 1;
    finish_up();
  end
endmodule